// File: doc/BRIEF.md
# Code-Group Link Synchronization Tracker

This block decides whether a receive link is in lock, judging from a stream of code groups that have already been aligned and decoded upstream. In each cycle it may be offered one code group. The group arrives with a valid strobe and two flags. One flag marks the group as a synchronization group. The other marks it as erroneous. The block keeps a single status output high while the link is judged to be in lock.

Three thresholds can be set. The first is the number of synchronization groups needed to gain lock. The second is the number of accumulated errors that drops lock. The third is the length of a run of good groups that forgives one counted error. Each threshold arrives on a configuration bus in minus-one encoding: a field value k selects a threshold of k+1. The block captures the buses while reset is held and keeps that copy until the next reset. When reset is released the block spends one cycle leaving its idle state and then starts hunting for lock.

Top module: `wa_sync_sm`

## Requirements
- R1: While `rst` is high, `sync_ok` is low and all counts are cleared. On the first clock edge after `rst` falls, the block moves from idle to hunting and ignores that cycle's group. Hunting uses the groups from the next cycle on.
- R2: While hunting, `sync_ok` goes high in the cycle after the valid group that brings the number of counted synchronization groups (valid=1, sync=1, err=0) to `cfg_acq_sel`+1. With an 8-bit field this covers 1 to 256.
- R3: While hunting, any valid group with err=1 sets the synchronization count back to zero. This holds even if its sync flag is also set. A valid group with both flags low leaves the count unchanged.
- R4: While in lock, each valid group with err=1 adds one to the error count. `sync_ok` goes low in the cycle after the group that brings the error count to `cfg_loss_sel`+1, which spans 1 to 256.
- R5: While in lock, every run of `cfg_run_sel`+1 consecutive valid groups with err=1 absent lowers the error count by one, for runs of 1 to 64. The run count restarts after each such decrement and on every erroneous group.
- R6: The error count never goes below zero. Good runs completed while the count is zero are lost and bank no credit against later errors.
- R7: On loss of lock, every count returns to zero. `sync_ok` stays low until a full `cfg_acq_sel`+1 synchronization groups have been counted again.
- R8: A cycle with `grp_valid` low changes neither `sync_ok` nor any count.
- R9: The configuration buses are sampled only while `rst` is high. Changing them after reset has no effect on any threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is held |
| grp_valid | input | 1 | A code group is present this cycle |
| grp_is_sync | input | 1 | The group is a synchronization group |
| grp_is_err | input | 1 | The group is erroneous; this flag takes precedence over the sync flag |
| cfg_acq_sel | input | ACQ_W (8) | Synchronization groups needed to gain lock, minus one |
| cfg_loss_sel | input | LOSS_W (8) | Errors needed to drop lock, minus one |
| cfg_run_sel | input | RUN_W (6) | Good-run length that forgives one error, minus one |
| sync_ok | output | 1 | High while the link is in lock |

## Verification
The embedded properties run on every cycle. They check that `sync_ok` only rises after a counted synchronization group and only falls after an erroneous one. They also check that the counts never pass their captured thresholds, that idle cycles leave the status unchanged, that counts are zero on loss of lock, and that the captured thresholds never move outside reset. Exact cycle counts can only be shown by the bench's scenarios: the lock and unlock points at the minimum and maximum thresholds, the count reset on errors while hunting, the forgiveness arithmetic including the floor at zero, and the proof that configuration changes after reset do nothing. The bench does this by comparing against a behavioural model on every clock.

// File: rtl/wa_sync_pkg.sv
package wa_sync_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_LOCK = 2'd2
   } wa_state_e;

endpackage

// File: rtl/wa_cfg_hold.sv
module wa_cfg_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("wa_cfg_hold: W must lie in 1..16");
   end

   // Capture only while reset is held; hold the value otherwise.
   always_ff @(posedge clk) begin
      if (rst) q <= d;
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst) !rst |=> $stable(q)); // R9

endmodule

// File: rtl/wa_run_counter.sv
module wa_run_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("wa_run_counter: W must lie in 1..16");
   end

   logic [W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt;
      if (clr)                  cnt_d = '0;
      else if (inc && !dec)     cnt_d = cnt + 1'b1;
      else if (dec && !inc && cnt != '0) cnt_d = cnt - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_d;
   end

   AST_NO_WRAP:    assert property (@(posedge clk) disable iff (rst) !(inc && !clr && !dec && (&cnt))); // R2
   AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
                      (dec && !inc && !clr && cnt == '0) |=> cnt == '0); // R6

endmodule

// File: rtl/wa_sync_sm.sv
module wa_sync_sm
   import wa_sync_pkg::*;
#(
   parameter int ACQ_W  = 8,
   parameter int LOSS_W = 8,
   parameter int RUN_W  = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              grp_valid,
   input  logic              grp_is_sync,
   input  logic              grp_is_err,
   input  logic [ACQ_W-1:0]  cfg_acq_sel,
   input  logic [LOSS_W-1:0] cfg_loss_sel,
   input  logic [RUN_W-1:0]  cfg_run_sel,
   output logic              sync_ok
);

   if (ACQ_W < 1 || ACQ_W > 16) begin : g_bad_acq
      $error("wa_sync_sm: ACQ_W must lie in 1..16");
   end
   if (LOSS_W < 1 || LOSS_W > 16) begin : g_bad_loss
      $error("wa_sync_sm: LOSS_W must lie in 1..16");
   end
   if (RUN_W < 1 || RUN_W > 16) begin : g_bad_run
      $error("wa_sync_sm: RUN_W must lie in 1..16");
   end

   wa_state_e state_q, state_d;

   logic [ACQ_W-1:0]  acq_q, acq_cnt;
   logic [LOSS_W-1:0] loss_q, err_cnt;
   logic [RUN_W-1:0]  run_q, run_cnt;

   wa_cfg_hold #(.W(ACQ_W))  u_acq_cfg  (.clk(clk), .rst(rst), .d(cfg_acq_sel),  .q(acq_q));
   wa_cfg_hold #(.W(LOSS_W)) u_loss_cfg (.clk(clk), .rst(rst), .d(cfg_loss_sel), .q(loss_q));
   wa_cfg_hold #(.W(RUN_W))  u_run_cfg  (.clk(clk), .rst(rst), .d(cfg_run_sel),  .q(run_q));

   // Group classification: the error flag dominates.
   logic bad_grp, good_grp, sync_grp;
   assign bad_grp  = grp_valid && grp_is_err;
   assign good_grp = grp_valid && !grp_is_err;
   assign sync_grp = good_grp && grp_is_sync;

   logic acq_clr, acq_inc;
   logic err_clr, err_inc, err_dec;
   logic run_clr, run_inc;
   logic acq_hit, loss_hit, run_hit;

   always_comb begin
      state_d  = state_q;
      acq_clr  = 1'b0;
      acq_inc  = 1'b0;
      err_clr  = 1'b0;
      err_inc  = 1'b0;
      err_dec  = 1'b0;
      run_clr  = 1'b0;
      run_inc  = 1'b0;
      acq_hit  = 1'b0;
      loss_hit = 1'b0;
      run_hit  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            acq_clr = 1'b1;
            err_clr = 1'b1;
            run_clr = 1'b1;
            state_d = ST_HUNT;
         end
         ST_HUNT: begin
            acq_hit = sync_grp && (acq_cnt == acq_q);
            if (bad_grp) begin
               acq_clr = 1'b1;
            end else if (acq_hit) begin
               acq_clr = 1'b1;
               state_d = ST_LOCK;
            end else if (sync_grp) begin
               acq_inc = 1'b1;
            end
         end
         ST_LOCK: begin
            loss_hit = bad_grp && (err_cnt == loss_q);
            run_hit  = good_grp && (run_cnt == run_q);
            if (loss_hit) begin
               err_clr = 1'b1;
               run_clr = 1'b1;
               acq_clr = 1'b1;
               state_d = ST_HUNT;
            end else if (bad_grp) begin
               err_inc = 1'b1;
               run_clr = 1'b1;
            end else if (run_hit) begin
               run_clr = 1'b1;
               err_dec = 1'b1;
            end else if (good_grp) begin
               run_inc = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   wa_run_counter #(.W(ACQ_W)) u_acq_ctr (
      .clk(clk), .rst(rst), .clr(acq_clr), .inc(acq_inc), .dec(1'b0), .cnt(acq_cnt));
   wa_run_counter #(.W(LOSS_W)) u_err_ctr (
      .clk(clk), .rst(rst), .clr(err_clr), .inc(err_inc), .dec(err_dec), .cnt(err_cnt));
   wa_run_counter #(.W(RUN_W)) u_run_ctr (
      .clk(clk), .rst(rst), .clr(run_clr), .inc(run_inc), .dec(1'b0), .cnt(run_cnt));

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign sync_ok = (state_q == ST_LOCK);

   AST_LOW_OUT_OF_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !sync_ok); // R1
   AST_RISE_ON_SYNC:     assert property (@(posedge clk) disable iff (rst)
                            $rose(sync_ok) |-> $past(grp_valid && grp_is_sync && !grp_is_err)); // R2
   AST_ACQ_BOUNDED:      assert property (@(posedge clk) disable iff (rst) acq_cnt <= acq_q); // R2
   AST_HUNT_ERR_ZEROES:  assert property (@(posedge clk) disable iff (rst)
                            (state_q == ST_HUNT && bad_grp) |=> acq_cnt == '0); // R3
   AST_FALL_ON_ERR:      assert property (@(posedge clk) disable iff (rst)
                            $fell(sync_ok) |-> $past(grp_valid && grp_is_err)); // R4
   AST_ERR_BOUNDED:      assert property (@(posedge clk) disable iff (rst) err_cnt <= loss_q); // R4
   AST_RUN_BOUNDED:      assert property (@(posedge clk) disable iff (rst) run_cnt <= run_q); // R5
   AST_LOSS_CLEAN:       assert property (@(posedge clk) disable iff (rst)
                            $fell(sync_ok) |-> (err_cnt == '0 && run_cnt == '0 && acq_cnt == '0)); // R7
   AST_IDLE_HOLDS:       assert property (@(posedge clk) disable iff (rst)
                            (!grp_valid && state_q != ST_IDLE) |=> ($stable(sync_ok) && $stable(err_cnt)
                            && $stable(acq_cnt) && $stable(run_cnt))); // R8

endmodule

// File: tb/tb_wa_sync_sm.sv
module tb_wa_sync_sm;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       grp_valid = 1'b0;
   logic       grp_is_sync = 1'b0;
   logic       grp_is_err = 1'b0;
   logic [7:0] cfg_acq_sel = 8'd2;
   logic [7:0] cfg_loss_sel = 8'd2;
   logic [5:0] cfg_run_sel = 6'd1;
   logic       sync_ok;

   int errors = 0;
   int checks = 0;
   string tag = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   wa_sync_sm dut (
      .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_is_sync(grp_is_sync),
      .grp_is_err(grp_is_err), .cfg_acq_sel(cfg_acq_sel), .cfg_loss_sel(cfg_loss_sel),
      .cfg_run_sel(cfg_run_sel), .sync_ok(sync_ok));

   // Behavioural reference: mode 0 idle, 1 hunting, 2 locked.
   int m_mode = 0, m_syncs = 0, m_errs = 0, m_good = 0;
   int t_acq = 3, t_loss = 3, t_run = 2;

   always @(posedge clk) begin
      if (rst) begin
         m_mode = 0; m_syncs = 0; m_errs = 0; m_good = 0;
         t_acq = int'(cfg_acq_sel) + 1;
         t_loss = int'(cfg_loss_sel) + 1;
         t_run = int'(cfg_run_sel) + 1;
      end else if (m_mode == 0) begin
         m_mode = 1;
      end else if (grp_valid) begin
         if (m_mode == 1) begin
            if (grp_is_err) m_syncs = 0;
            else if (grp_is_sync) begin
               m_syncs++;
               if (m_syncs >= t_acq) begin m_mode = 2; m_syncs = 0; end
            end
         end else begin
            if (grp_is_err) begin
               m_good = 0;
               m_errs++;
               if (m_errs >= t_loss) begin m_mode = 1; m_errs = 0; end
            end else begin
               m_good++;
               if (m_good >= t_run) begin
                  m_good = 0;
                  m_errs = (m_errs > 0) ? m_errs - 1 : 0;
               end
            end
         end
      end
   end

   task automatic check_out();
      logic exp;
      exp = (m_mode == 2);
      checks++;
      if (sync_ok !== exp) begin
         errors++;
         $display("FAIL %s: sync_ok=%0b expected %0b at %0t", tag, sync_ok, exp, $time);
      end
   endtask

   // Drive one cycle of input, let the edge pass, compare at the falling edge.
   task automatic cyc(input logic v, input logic s, input logic e);
      grp_valid = v; grp_is_sync = s; grp_is_err = e;
      @(posedge clk);
      @(negedge clk);
      check_out();
   endtask

   task automatic do_reset(input logic [7:0] a, input logic [7:0] l, input logic [5:0] r);
      @(negedge clk);
      rst = 1'b1;
      cfg_acq_sel = a; cfg_loss_sel = l; cfg_run_sel = r;
      grp_valid = 1'b0; grp_is_sync = 1'b0; grp_is_err = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      tag = "R1";
      check_out();
      rst = 1'b0;
   endtask

   task automatic syncs(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0);
   endtask

   task automatic errs(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b1);
   endtask

   task automatic goods(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // Thresholds: acquire 3, lose 3, forgive after 2 good groups.
      do_reset(8'd2, 8'd2, 6'd1);
      tag = "R1"; cyc(1'b1, 1'b1, 1'b0);          // ignored while leaving idle
      tag = "R3"; syncs(2); errs(1); syncs(2);
      cyc(1'b1, 1'b1, 1'b1);                      // both flags: counts as error
      syncs(2); cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b0, 1'b0);
      tag = "R8"; cyc(1'b0, 1'b1, 1'b0); cyc(1'b0, 1'b0, 1'b1);
      tag = "R2"; syncs(1); syncs(2);
      tag = "R6"; goods(7); errs(2);
      tag = "R8"; cyc(1'b0, 1'b0, 1'b1); cyc(1'b0, 1'b0, 1'b1);
      tag = "R5"; goods(2); errs(1); goods(1); errs(1); goods(4); errs(1); goods(1);
      tag = "R4"; errs(2);
      tag = "R7"; syncs(2); cyc(1'b0, 1'b1, 1'b0); syncs(1); syncs(1);
      tag = "R9"; cfg_acq_sel = 8'd0; cfg_loss_sel = 8'd0; cfg_run_sel = 6'd0;
      errs(2); goods(3); errs(1); syncs(2); syncs(1); syncs(1);

      // Minimum thresholds.
      do_reset(8'd0, 8'd0, 6'd0);
      tag = "R2"; cyc(1'b0, 1'b0, 1'b0); syncs(1);
      tag = "R5"; goods(3);
      tag = "R4"; errs(1);
      tag = "R2"; syncs(1);

      // Maximum thresholds.
      do_reset(8'd255, 8'd255, 6'd63);
      tag = "R2"; cyc(1'b0, 1'b0, 1'b0); syncs(255); syncs(1);
      tag = "R4"; errs(255);
      tag = "R5"; goods(64); errs(1);
      tag = "R4"; errs(1);
      tag = "R7"; syncs(255); syncs(1);

      // Mixed traffic.
      do_reset(8'd3, 8'd4, 6'd2);
      tag = "R5";
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 99));
         cyc(r < 85, r < 40, (r >= 40 && r < 48) || r == 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule